// File: doc/BRIEF.md
# Programmable interval timer channel

This block is a single counter channel of a programmable interval timer that sits on an 8-bit processor bus. Software first writes a control byte to a shared control port. The channel acts on that byte only when the byte's two top bits carry the channel's own index. The control byte chooses binary or decimal (BCD) counting, the counting mode and how the 16-bit count moves through the 8-bit data port. The initial count then arrives as one or two byte writes on the channel's data port. The channel counts down once per enabled counting edge and raises its output when the count reaches zero. That output can serve as an interrupt request.

Counting advances on system clock edges where the count-enable input `cnt_en` is high. This input stands in for the external counting clock. A count of zero stands for the largest count in either number format. A latch command copies the running count into a holding register, so that software can read a stable value in two byte reads while the counter keeps running. Only the interrupt-on-terminal-count behaviour, mode 0, is implemented. In any other mode the count still runs but the output never rises.

Top module: `pit_channel`

## Requirements
- R1: After synchronous reset the output is low, the count is zero, word access (LSB then MSB) is selected, binary format is selected, and both byte pointers point at the LSB.
- R2: A control byte written to address CTRL_ADDR is acted on only when bits [7:6] equal CHAN_ID. In that byte, bit 0 set selects BCD, bits [3:1] select the mode and bits [5:4] select the access code. A control byte with a different index changes nothing in this channel, including a latch command.
- R3: A control byte for this channel with access code other than 00 drives the output low, halts counting, drops any held latch, and returns both byte pointers to the LSB.
- R4: With access code 11, the first data write is held as the LSB and the second write supplies the MSB. The full count loads on the first enabled counting edge after the second write, and each later enabled edge decrements the count by one.
- R5: Access code 01 writes and reads only the LSB, and code 10 only the MSB. The byte that is not written loads as zero, and each single write completes a count.
- R6: In mode 0 the output rises on the enabled edge where the count steps from 1 to 0. It then stays high while the count keeps wrapping, until a new count completes or a control byte is written; either of these drives it low.
- R7: A loaded count of zero is the maximum: 65536 decrements (binary) or 10000 decrements (BCD) before the output rises. The load itself never raises the output.
- R8: In BCD mode each 4-bit nibble is one decimal digit, and the count decrements in decimal with a borrow between digits. 0000 steps to 9999.
- R9: A control byte with access code 00 copies the live count into a holding register. Data reads return the held value until every byte that the access code needs has been read. Further latch commands are ignored until then.
- R10: With access code 11, data reads alternate LSB then MSB. With codes 01 and 10, every read returns the one selected byte. Without a held latch, reads return the live count.
- R11: With a nonzero mode field the count loads and decrements as in mode 0, but the output stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_en | input | 1 | Counting edge enable (loads and decrements happen only when high) |
| bus_sel | input | 1 | Chip select, active high |
| bus_addr | input | ADDR_W | Port select: CTRL_ADDR is the control port, CHAN_ID is this channel's data port |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data byte, valid during the read-strobe cycle |
| timer_out | output | 1 | Terminal count output |

## Verification
A bus write takes effect at the clock edge inside its strobe cycle. The output level it forces is therefore checked at the following falling edge. A completed count appears in the counter only after one more enabled counting edge, and the bench reads the live count before that edge to confirm the count has not yet loaded. Read data is combinational during the read-strobe cycle: the monitor samples it a quarter period after the falling edge that raised the strobe, before the edge that advances the byte pointer. Counting is driven one counting edge at a time, and every terminal-count and wrap check is sampled at the falling edge after the exact counting edge on which the step is due.

// File: rtl/pit_pkg.sv
// Package: shared widths, access codes, control byte layout and the
// decrement helpers used by the interval timer channel.
// Assumes a 16-bit count carried over an 8-bit bus in two bytes.
package pit_pkg;

    localparam int BYTE_W  = 8;
    localparam int CNT_W   = 2 * BYTE_W;
    localparam int DIGIT_W = 4;
    localparam int DIGITS  = CNT_W / DIGIT_W;

    // Access code in control bits [5:4]
    typedef enum logic [1:0] {
        ACC_LATCH = 2'b00,
        ACC_LSB   = 2'b01,
        ACC_MSB   = 2'b10,
        ACC_WORD  = 2'b11
    } access_e;

    // Control byte, MSB first: index, access, mode, format
    typedef struct packed {
        logic [1:0] sc;
        access_e    acc;
        logic [2:0] mode;
        logic       bcd;
    } ctrl_word_t;

    // Decimal decrement with borrow across nibbles; all zero wraps to all nines
    function automatic logic [CNT_W-1:0] bcd_decrement(input logic [CNT_W-1:0] v);
        logic [CNT_W-1:0] r;
        logic             borrow;
        r      = v;
        borrow = 1'b1;
        for (int d = 0; d < DIGITS; d++) begin
            if (borrow) begin
                if (v[d*DIGIT_W +: DIGIT_W] == '0) begin
                    r[d*DIGIT_W +: DIGIT_W] = DIGIT_W'(9);
                end else begin
                    r[d*DIGIT_W +: DIGIT_W] = v[d*DIGIT_W +: DIGIT_W] - 1'b1;
                    borrow = 1'b0;
                end
            end
        end
        return r;
    endfunction

    // Binary decrement, wrapping 0 to all ones
    function automatic logic [CNT_W-1:0] bin_decrement(input logic [CNT_W-1:0] v);
        return v - 1'b1;
    endfunction

endpackage

// File: rtl/pit_bus_decode.sv
// Bus decode and write sequencing for one channel.
// Decodes control bytes addressed to this channel, keeps the access code,
// format and mode, and assembles the 16-bit initial count from byte writes.
// Assumes one-cycle strobes and a synchronous bus.
module pit_bus_decode
    import pit_pkg::*;
#(
    parameter int CHAN_ID   = 1,
    parameter int CTRL_ADDR = 3,
    parameter int ADDR_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BYTE_W-1:0] bus_wdata,
    output access_e           acc_q,
    output logic              bcd_q,
    output logic              mode_zero,
    output logic              ctrl_wr,
    output logic              latch_cmd,
    output logic              data_rd,
    output logic              init_done,
    output logic [CNT_W-1:0]  init_val
);

    localparam logic [1:0]        SC_CODE   = CHAN_ID[1:0];
    localparam logic [ADDR_W-1:0] DATA_PORT = ADDR_W'(CHAN_ID);
    localparam logic [ADDR_W-1:0] CTRL_PORT = ADDR_W'(CTRL_ADDR);

    ctrl_word_t        cw;
    logic              ctrl_hit;
    logic              data_wr;
    logic              wptr_q;
    logic [BYTE_W-1:0] lsb_hold_q;
    logic [2:0]        mode_q;

    // Strobe decode for the control port and this channel's data port
    always_comb begin
        cw        = ctrl_word_t'(bus_wdata);
        ctrl_hit  = bus_sel && bus_wr && (bus_addr == CTRL_PORT) && (cw.sc == SC_CODE);
        latch_cmd = ctrl_hit && (cw.acc == ACC_LATCH);
        ctrl_wr   = ctrl_hit && (cw.acc != ACC_LATCH);
        data_wr   = bus_sel && bus_wr && (bus_addr == DATA_PORT);
        data_rd   = bus_sel && bus_rd && (bus_addr == DATA_PORT);
        mode_zero = (mode_q == 3'd0);
    end

    // Completion of a count and the value it carries
    always_comb begin
        init_done = data_wr && ((acc_q != ACC_WORD) || wptr_q);
        case (acc_q)
            ACC_LSB: init_val = {{BYTE_W{1'b0}}, bus_wdata};
            ACC_MSB: init_val = {bus_wdata, {BYTE_W{1'b0}}};
            default: init_val = {bus_wdata, lsb_hold_q};
        endcase
    end

    // Configuration registers and LSB/MSB write pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q      <= ACC_WORD;
            bcd_q      <= 1'b0;
            mode_q     <= 3'd0;
            wptr_q     <= 1'b0;
            lsb_hold_q <= '0;
        end else if (ctrl_wr) begin
            acc_q  <= cw.acc;
            bcd_q  <= cw.bcd;
            mode_q <= cw.mode;
            wptr_q <= 1'b0;
        end else if (data_wr && (acc_q == ACC_WORD)) begin
            if (!wptr_q) begin
                lsb_hold_q <= bus_wdata;
                wptr_q     <= 1'b1;
            end else begin
                wptr_q <= 1'b0;
            end
        end
    end

    // R3: a control write always leaves the write pointer at the LSB
    assert_wptr_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> !wptr_q);

    // R4: a first word-mode byte never completes a count
    assert_word_needs_two_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && acc_q == ACC_WORD && !wptr_q && !ctrl_wr) |=> wptr_q);

endmodule

// File: rtl/pit_down_counter.sv
// Down counter and terminal-count output for one channel.
// Holds a completed count until the next enabled counting edge, then loads
// it and decrements in binary or BCD on each later enabled edge.
// Assumes control writes and count completions never coincide with each other.
module pit_down_counter
    import pit_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             bcd_mode,
    input  logic             mode_zero,
    input  logic             ctrl_wr,
    input  logic             init_done,
    input  logic [CNT_W-1:0] init_val,
    output logic [CNT_W-1:0] count_q,
    output logic             out_q
);

    logic [CNT_W-1:0] init_q;
    logic [CNT_W-1:0] next_count;
    logic             load_pend_q;
    logic             running_q;
    logic             at_one;

    // Next value of a running count in the selected format
    always_comb begin
        next_count = bcd_mode ? bcd_decrement(count_q) : bin_decrement(count_q);
        at_one     = (count_q == CNT_W'(1));
    end

    // Load, decrement and terminal-count output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q     <= '0;
            init_q      <= '0;
            load_pend_q <= 1'b0;
            running_q   <= 1'b0;
            out_q       <= 1'b0;
        end else if (ctrl_wr) begin
            load_pend_q <= 1'b0;
            running_q   <= 1'b0;
            out_q       <= 1'b0;
        end else if (init_done) begin
            init_q      <= init_val;
            load_pend_q <= 1'b1;
            out_q       <= 1'b0;
        end else if (cnt_en) begin
            if (load_pend_q) begin
                count_q     <= init_q;
                load_pend_q <= 1'b0;
                running_q   <= 1'b1;
            end else if (running_q) begin
                count_q <= next_count;
                if (at_one && mode_zero) begin
                    out_q <= 1'b1;
                end
            end
        end
    end

    // R6: once high, the output holds until a new count or control write
    assert_out_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_q && !ctrl_wr && !init_done) |=> out_q);

    // R6: the output rises only together with a zero count
    assert_out_at_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_q) |-> (count_q == '0));

    // R7: a load never raises the output
    assert_load_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && load_pend_q && !ctrl_wr && !init_done && !out_q) |=> !out_q);

    // R11: only mode 0 lets the output rise
    assert_mode_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_q) |-> $past(mode_zero));

endmodule

// File: rtl/pit_read_port.sv
// Read path for one channel: latch holding register and byte read sequencing.
// Returns the held latch when one is pending, otherwise the live count.
// Assumes latch commands and data reads arrive in different cycles.
module pit_read_port
    import pit_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  access_e           acc,
    input  logic              ctrl_wr,
    input  logic              latch_cmd,
    input  logic              data_rd,
    input  logic [CNT_W-1:0]  count_in,
    output logic [BYTE_W-1:0] rdata
);

    logic [CNT_W-1:0] latch_q;
    logic             latched_q;
    logic             rptr_q;
    logic             hi_sel;
    logic             last_byte;
    logic [CNT_W-1:0] src;

    // Byte selection from the access code and read pointer
    always_comb begin
        hi_sel    = (acc == ACC_MSB) || ((acc == ACC_WORD) && rptr_q);
        last_byte = (acc != ACC_WORD) || rptr_q;
        src       = latched_q ? latch_q : count_in;
        rdata     = hi_sel ? src[CNT_W-1:BYTE_W] : src[BYTE_W-1:0];
    end

    // Latch capture, release and read pointer advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q   <= '0;
            latched_q <= 1'b0;
            rptr_q    <= 1'b0;
        end else if (ctrl_wr) begin
            latched_q <= 1'b0;
            rptr_q    <= 1'b0;
        end else begin
            if (latch_cmd && !latched_q) begin
                latch_q   <= count_in;
                latched_q <= 1'b1;
            end
            if (data_rd) begin
                rptr_q <= (acc == ACC_WORD) ? !rptr_q : 1'b0;
                if (last_byte) begin
                    latched_q <= 1'b0;
                end
            end
        end
    end

    // R9: a held latch stays frozen until its reads finish
    assert_latch_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (latched_q && !ctrl_wr && !data_rd) |=> (latched_q && $stable(latch_q)));

    // R10: the first word-mode read moves the pointer to the MSB
    assert_rptr_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && acc == ACC_WORD && !rptr_q && !ctrl_wr) |=> rptr_q);

endmodule

// File: rtl/pit_channel.sv
// Top of one interval timer channel: bus decode, down counter and read port.
// Mode 0 (interrupt on terminal count) only; cnt_en marks counting edges.
// Assumes one bus strobe per cycle and synchronous inputs.
module pit_channel
    import pit_pkg::*;
#(
    parameter int CHAN_ID   = 1,
    parameter int CTRL_ADDR = 3,
    parameter int ADDR_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_en,
    input  logic              bus_sel,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              timer_out
);

    access_e          acc;
    logic             bcd;
    logic             mode_zero;
    logic             ctrl_wr;
    logic             latch_cmd;
    logic             data_rd;
    logic             init_done;
    logic [CNT_W-1:0] init_val;
    logic [CNT_W-1:0] count;

    pit_bus_decode #(
        .CHAN_ID  (CHAN_ID),
        .CTRL_ADDR(CTRL_ADDR),
        .ADDR_W   (ADDR_W)
    ) u_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_sel  (bus_sel),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_wdata(bus_wdata),
        .acc_q    (acc),
        .bcd_q    (bcd),
        .mode_zero(mode_zero),
        .ctrl_wr  (ctrl_wr),
        .latch_cmd(latch_cmd),
        .data_rd  (data_rd),
        .init_done(init_done),
        .init_val (init_val)
    );

    pit_down_counter u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_en   (cnt_en),
        .bcd_mode (bcd),
        .mode_zero(mode_zero),
        .ctrl_wr  (ctrl_wr),
        .init_done(init_done),
        .init_val (init_val),
        .count_q  (count),
        .out_q    (timer_out)
    );

    pit_read_port u_read (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc      (acc),
        .ctrl_wr  (ctrl_wr),
        .latch_cmd(latch_cmd),
        .data_rd  (data_rd),
        .count_in (count),
        .rdata    (bus_rdata)
    );

    // R2: one strobe class at a time reaches the channel
    assert_one_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctrl_wr, latch_cmd, init_done, data_rd}));

endmodule

// File: tb/tb_pit_channel.sv
`timescale 1ns/1ps
module tb_pit_channel;

    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] CTRL = 2'd3;
    localparam logic [1:0] DATA = 2'd1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnt_en = 1'b0;
    logic       bus_sel = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       timer_out;

    int n_checks = 0;
    int n_fails  = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    pit_channel dut (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .bus_sel(bus_sel),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .timer_out(timer_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check_out(input logic exp, input string req);
        n_checks++;
        if (timer_out !== exp) begin
            n_fails++;
            $display("FAIL %s timer_out actual %0b expected %0b", req, timer_out, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    // Driver: pushes the expected byte, then strobes a read
    task automatic bus_read(input logic [7:0] exp, input string req);
        @(negedge clk);
        exp_q.push_back(exp);
        tag_q.push_back(req);
        bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = DATA;
        @(negedge clk);
        bus_sel = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic tick(input int n);
        @(negedge clk);
        cnt_en = 1'b1;
        repeat (n) @(negedge clk);
        cnt_en = 1'b0;
    endtask

    task automatic finish_run();
        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_checks++; n_fails++;
            $display("FAIL scoreboard %0d reads never observed", exp_q.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    // Monitor: compares read data a quarter period after the strobe rises
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            if (bus_sel && bus_rd && bus_addr == DATA) begin
                n_checks++;
                if (exp_q.size() == 0) begin
                    n_fails++;
                    $display("FAIL unexpected read actual %02h expected none", bus_rdata);
                end else begin
                    logic [7:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (bus_rdata !== e) begin
                        n_fails++;
                        $display("FAIL %s bus_rdata actual %02h expected %02h", t, bus_rdata, e);
                    end
                end
            end
        end
    end

    // Watchdog
    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++; n_fails++;
        $display("FAIL watchdog expired actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        check_out(1'b0, "R1 reset");
        bus_read(8'h00, "R1 reset LSB");
        bus_read(8'h00, "R1 reset MSB");

        // R4 word write, load on next enabled edge
        bus_write(CTRL, 8'h70);
        bus_write(DATA, 8'h05);
        bus_write(DATA, 8'h00);
        bus_read(8'h00, "R4 not loaded yet LSB");
        bus_read(8'h00, "R4 not loaded yet MSB");
        tick(1);
        bus_read(8'h05, "R4 loaded LSB");
        bus_read(8'h00, "R4 loaded MSB");
        tick(2);
        bus_write(CTRL, 8'h40);
        tick(1);
        bus_read(8'h03, "R9 latched LSB");
        bus_read(8'h00, "R9 latched MSB");
        bus_read(8'h02, "R10 live LSB after release");
        bus_read(8'h00, "R10 live MSB after release");
        check_out(1'b0, "R6 before terminal");
        tick(1);
        check_out(1'b0, "R6 at count 1");
        tick(1);
        check_out(1'b1, "R6 terminal count");
        tick(1);
        check_out(1'b1, "R6 held while wrapping");
        bus_read(8'hFF, "R6 wrap LSB");
        bus_read(8'hFF, "R6 wrap MSB");

        // R6 new count drives output low
        bus_write(DATA, 8'h02);
        check_out(1'b1, "R6 high after LSB only");
        bus_write(DATA, 8'h00);
        check_out(1'b0, "R6 new count clears output");
        tick(2);
        check_out(1'b0, "R6 count 1");
        tick(1);
        check_out(1'b1, "R6 second terminal");

        // R3 control write: output low, halt, pointer reset
        bus_write(CTRL, 8'h70);
        check_out(1'b0, "R3 control clears output");
        tick(3);
        bus_read(8'h00, "R3 halted LSB");
        bus_read(8'h00, "R3 halted MSB");
        bus_write(DATA, 8'h34);
        bus_write(CTRL, 8'h70);
        bus_write(DATA, 8'h03);
        bus_write(DATA, 8'h00);
        tick(1);
        bus_read(8'h03, "R3 pointer reset LSB");
        bus_read(8'h00, "R3 pointer reset MSB");

        // R7 binary zero is 65536
        bus_write(CTRL, 8'h70);
        bus_write(DATA, 8'h00);
        bus_write(DATA, 8'h00);
        tick(1);
        check_out(1'b0, "R7 load of zero quiet");
        tick(65535);
        check_out(1'b0, "R7 binary one step early");
        bus_read(8'h01, "R7 binary count 1 LSB");
        bus_read(8'h00, "R7 binary count 1 MSB");
        tick(1);
        check_out(1'b1, "R7 binary 65536 terminal");

        // R8 BCD borrow
        bus_write(CTRL, 8'h71);
        bus_write(DATA, 8'h00);
        bus_write(DATA, 8'h10);
        tick(2);
        bus_read(8'h99, "R8 1000 to 0999 LSB");
        bus_read(8'h09, "R8 1000 to 0999 MSB");
        tick(1);
        bus_read(8'h98, "R8 0998 LSB");
        bus_read(8'h09, "R8 0998 MSB");

        // R7/R8 BCD zero is 10000
        bus_write(CTRL, 8'h71);
        bus_write(DATA, 8'h00);
        bus_write(DATA, 8'h00);
        tick(2);
        bus_read(8'h99, "R8 0000 to 9999 LSB");
        bus_read(8'h99, "R8 0000 to 9999 MSB");
        check_out(1'b0, "R7 BCD after first step");
        tick(9998);
        check_out(1'b0, "R7 BCD one step early");
        tick(1);
        check_out(1'b1, "R7 BCD 10000 terminal");

        // R5 single byte modes
        bus_write(CTRL, 8'h50);
        bus_write(DATA, 8'h07);
        tick(2);
        bus_read(8'h06, "R5 LSB only");
        bus_read(8'h06, "R10 LSB only repeats");
        bus_write(CTRL, 8'h60);
        bus_write(DATA, 8'h02);
        tick(2);
        bus_read(8'h01, "R5 MSB only 0200 to 01FF");

        // R9 latch with single byte access
        bus_write(CTRL, 8'h50);
        bus_write(DATA, 8'h09);
        tick(1);
        bus_write(CTRL, 8'h40);
        tick(1);
        bus_read(8'h09, "R9 single byte latch");
        bus_write(CTRL, 8'h40);
        tick(1);
        bus_read(8'h08, "R9 relatch after release");

        // R9 second latch ignored
        bus_write(CTRL, 8'h70);
        bus_write(DATA, 8'h10);
        bus_write(DATA, 8'h00);
        tick(1);
        bus_write(CTRL, 8'h40);
        tick(2);
        bus_write(CTRL, 8'h40);
        tick(1);
        bus_read(8'h10, "R9 first latch kept LSB");
        bus_read(8'h00, "R9 first latch kept MSB");
        bus_read(8'h0D, "R9 live after release LSB");
        bus_read(8'h00, "R9 live after release MSB");

        // R2 other channel index ignored
        bus_write(CTRL, 8'h90);
        tick(1);
        bus_read(8'h0C, "R2 foreign control LSB");
        bus_read(8'h00, "R2 foreign control MSB");
        bus_write(CTRL, 8'h00);
        tick(1);
        bus_read(8'h0B, "R2 foreign latch LSB");
        bus_read(8'h00, "R2 foreign latch MSB");

        // R11 nonzero mode keeps output low
        bus_write(CTRL, 8'h72);
        bus_write(DATA, 8'h02);
        bus_write(DATA, 8'h00);
        tick(3);
        bus_read(8'h00, "R11 count reached zero LSB");
        bus_read(8'h00, "R11 count reached zero MSB");
        check_out(1'b0, "R11 output stays low");

        finish_run();
    end

endmodule